// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital control section of a stepped resistor tap selector with 32 tap positions joined by 31 series elements. It watches two asynchronous control lines, an active-low select and an up/down line, and keeps a 5-bit wiper position. While the block is selected, each qualified pulse on the up/down line moves the wiper one tap. The position is decoded into a one-hot tap-enable vector, so exactly one tap switch is closed at any moment.

Both lines pass through synchronizer chains. The up/down line then goes through a width filter, and only a level held for at least `MIN_PULSE` clocks counts as a change. The direction of travel is fixed when the block is selected. If the filtered up/down level is high at that moment, the wiper moves toward the high end (higher index). If it is low, the wiper moves toward index 0. Only filtered transitions toward that captured level advance the wiper, and the position clamps at both ends. When the block is deselected it returns to standby and holds its position until the next selection. Reset places the wiper at midscale.

The controller has three states, named below.

| State | Meaning |
|---|---|
| `ST_IDLE` | Deselected. Standby flag high, no stepping. |
| `ST_UP` | Selected with upward travel. Each filtered low-to-high transition adds one. |
| `ST_DOWN` | Selected with downward travel. Each filtered high-to-low transition subtracts one. |

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_UP` | Synchronized select active while the filtered up/down level is 1 |
| `ST_IDLE` to `ST_DOWN` | Synchronized select active while the filtered up/down level is 0 |
| `ST_UP` / `ST_DOWN` to `ST_IDLE` | Synchronized select released |

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset the position is 16 (midscale), tap-enable bit 16 alone is set, and the standby flag is 1.
- R2: While `sel_n` is high (after synchronization) the standby flag is 1, and no activity on the up/down line changes the position.
- R3: The direction is captured from the filtered up/down level when selection begins (1 = up, 0 = down) and is held until deselection. Transitions in the other direction never move the wiper.
- R4: While selected, each filtered transition toward the captured level changes the position by exactly one. Upward travel adds one and downward travel subtracts one.
- R5: An up/down level that lasts fewer than `MIN_PULSE` (default 15) clock cycles is ignored. A level that lasts exactly `MIN_PULSE` cycles is accepted.
- R6: The position saturates. An up step at 31 leaves 31, and a down step at 0 leaves 0.
- R7: The position is held unchanged across a deselection and is the starting point of the next selection.
- R8: The tap-enable output has exactly one bit set, at the index equal to the position, in the same cycle as the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Asynchronous select, active low |
| updn | input | 1 | Asynchronous up/down step line |
| wiper_pos | output | 5 | Current wiper position, 0 to 31 |
| tap_en | output | 32 | One-hot tap enables, bit i closes tap i |
| standby | output | 1 | High while deselected |

## Verification
The bench runs the wiper into both end stops with more pulses than the distance to travel. A design that wraps would jump to the opposite end, and the next comparison would show it. It sends up/down pulses of `MIN_PULSE-1` and exactly `MIN_PULSE` cycles, so a filter that is off by one would either drop the valid pulse or take the short one. It toggles the line while the block is deselected and checks the position across reselection, which catches a design that steps in standby or reloads midscale. Because the reference model compares the position, the decode and the flag on every clock, a step taken one cycle early or late shows up as a mismatch.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Controller states; encoding is internal only.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } wiper_state_e;

endpackage

// File: rtl/wiper_sync.sv
// Multi-stage synchronizer for one asynchronous control line.
module wiper_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wiper_pulse_filter.sv
// Accepts a new level only after it has persisted MIN_PULSE clocks;
// emits a one-cycle strobe coincident with each accepted change.
module wiper_pulse_filter #(
    parameter int   MIN_PULSE = 15,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             accept;

    assign accept = (level_i != level_o) && (run_cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_o <= RST_LEVEL;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            rise_o <= accept &&  level_i;
            fall_o <= accept && !level_i;
            if (level_i == level_o) begin
                run_cnt <= '0;
            end else if (accept) begin
                run_cnt <= '0;
                level_o <= level_i;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R5: an accepted level must have been present at the input the cycle before
    assert_filter_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |-> ($past(level_i) == level_o));
endmodule

// File: rtl/wiper_step_fsm.sv
// Selection/direction state machine with saturating position register.
module wiper_step_fsm
    import wiper_pkg::*;
#(
    parameter int TAP_BITS  = 5,
    parameter int RESET_POS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_i,
    input  logic                dir_level_i,
    input  logic                step_rise_i,
    input  logic                step_fall_i,
    output logic [TAP_BITS-1:0] pos_o,
    output logic                standby_o
);
    localparam logic [TAP_BITS-1:0] POS_MAX  = {TAP_BITS{1'b1}};
    localparam logic [TAP_BITS-1:0] POS_INIT = TAP_BITS'(RESET_POS);

    wiper_state_e state_q, state_d;
    logic         inc, dec;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_i) state_d = dir_level_i ? ST_UP : ST_DOWN;
            ST_UP:   if (!sel_i) state_d = ST_IDLE;
            ST_DOWN: if (!sel_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        standby_o = 1'b0;
        inc       = 1'b0;
        dec       = 1'b0;
        unique case (state_q)
            ST_IDLE: standby_o = 1'b1;
            ST_UP:   inc = step_rise_i;
            ST_DOWN: dec = step_fall_i;
            default: standby_o = 1'b1;
        endcase
    end

    // Saturating position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_o <= POS_INIT;
        end else if (inc && (pos_o != POS_MAX)) begin
            pos_o <= pos_o + 1'b1;
        end else if (dec && (pos_o != '0)) begin
            pos_o <= pos_o - 1'b1;
        end
    end

    // R2, R7: no movement while deselected
    assert_hold_in_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |=> $stable(pos_o));
    // R3: upward selection never lowers the position
    assert_up_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) |=> (pos_o >= $past(pos_o)));
    // R3: downward selection never raises the position
    assert_down_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |=> (pos_o <= $past(pos_o)));
    // R4, R6: at most one tap per cycle, no wrap between the ends
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_o == $past(pos_o)) || (pos_o == $past(pos_o) + 1'b1)
         || (pos_o == $past(pos_o) - 1'b1)) && !((pos_o == '0) && ($past(pos_o) == POS_MAX))
         && !((pos_o == POS_MAX) && ($past(pos_o) == '0)));
endmodule

// File: rtl/wiper_tap_decode.sv
// Binary position to one-hot tap enables.
module wiper_tap_decode #(
    parameter int TAP_BITS = 5,
    parameter int NUM_TAPS = 32
) (
    input  logic [TAP_BITS-1:0] pos_i,
    output logic [NUM_TAPS-1:0] tap_o
);
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == TAP_BITS'(t));
    end
endmodule

// File: rtl/wiper_step_ctrl.sv
// Top: synchronizers, up/down width filter, controller, tap decode.
module wiper_step_ctrl #(
    parameter int TAP_BITS    = 5,
    parameter int MIN_PULSE   = 15,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_POS   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_n,
    input  logic                          updn,
    output logic [TAP_BITS-1:0]           wiper_pos,
    output logic [(1 << TAP_BITS)-1:0]    tap_en,
    output logic                          standby
);
    localparam int NUM_TAPS = 1 << TAP_BITS;

    logic sel_n_s, updn_s;
    logic updn_f, updn_rise, updn_fall;

    wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_n_s)
    );

    wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_updn (
        .clk(clk), .rst_n(rst_n), .d(updn), .q(updn_s)
    );

    wiper_pulse_filter #(.MIN_PULSE(MIN_PULSE), .RST_LEVEL(1'b0)) u_filter (
        .clk(clk), .rst_n(rst_n), .level_i(updn_s),
        .level_o(updn_f), .rise_o(updn_rise), .fall_o(updn_fall)
    );

    wiper_step_fsm #(.TAP_BITS(TAP_BITS), .RESET_POS(RESET_POS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_i(!sel_n_s), .dir_level_i(updn_f),
        .step_rise_i(updn_rise), .step_fall_i(updn_fall),
        .pos_o(wiper_pos), .standby_o(standby)
    );

    wiper_tap_decode #(.TAP_BITS(TAP_BITS), .NUM_TAPS(NUM_TAPS)) u_decode (
        .pos_i(wiper_pos), .tap_o(tap_en)
    );

    // R8: exactly one tap closed, at the position index
    assert_onehot_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_en) == 1) && tap_en[wiper_pos]);
    // R2: a released select leads to standby within the synchronizer delay
    assert_standby_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_s && $past(sel_n_s)) |-> standby);
endmodule

// File: tb/tb_wiper_step_ctrl.sv
module tb_wiper_step_ctrl;
    localparam int MINP = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        updn = 1'b0;
    logic [4:0]  wiper_pos;
    logic [31:0] tap_en;
    logic        standby;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Behavioural reference
    int m_s1_cs, m_s2_cs, m_s1_ud, m_s2_ud;
    int m_flt, m_cnt, m_rise, m_fall, m_state, m_pos;

    always #10 clk = ~clk;

    wiper_step_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .updn(updn),
        .wiper_pos(wiper_pos), .tap_en(tap_en), .standby(standby)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1_cs = 1; m_s2_cs = 1; m_s1_ud = 0; m_s2_ud = 0;
            m_flt = 0; m_cnt = 0; m_rise = 0; m_fall = 0;
            m_state = 0; m_pos = 16;
        end else begin
            if (m_state == 1 && m_rise == 1) m_pos = (m_pos < 31) ? m_pos + 1 : 31;
            else if (m_state == 2 && m_fall == 1) m_pos = (m_pos > 0) ? m_pos - 1 : 0;
            if (m_s2_cs == 1) m_state = 0;
            else if (m_state == 0) m_state = (m_flt == 1) ? 1 : 2;
            m_rise = 0; m_fall = 0;
            if (m_s2_ud == m_flt) m_cnt = 0;
            else if (m_cnt == MINP - 1) begin
                m_flt = m_s2_ud; m_cnt = 0;
                if (m_flt == 1) m_rise = 1; else m_fall = 1;
            end else m_cnt = m_cnt + 1;
            m_s2_cs = m_s1_cs; m_s1_cs = int'(sel_n);
            m_s2_ud = m_s1_ud; m_s1_ud = int'(updn);
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Every-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_req, " position"}, int'(wiper_pos), m_pos);
            n_checks++;
            if (tap_en != (32'd1 << wiper_pos) || $countones(tap_en) != 1) begin
                n_fail++;
                $display("FAIL R8: actual tap_en %h expected %h", tap_en, 32'd1 << wiper_pos);
            end
            check({cur_req, " standby"}, int'(standby), (m_state == 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Move updn to 'away' for w_away cycles, then back for w_back cycles
    task automatic pulse(logic away, int w_away, int w_back);
        updn = away;
        wait_cyc(w_away);
        updn = ~away;
        wait_cyc(w_back);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1: reset state
        check("R1", int'(wiper_pos), 16);
        check("R1", int'(tap_en[16]), 1);
        check("R1", int'(standby), 1);

        // R2: activity while deselected is ignored
        cur_req = "R2";
        for (int i = 0; i < 4; i++) pulse(1'b1, 20, 20);
        check("R2", int'(wiper_pos), 16);
        check("R2", int'(standby), 1);

        // R3/R4: select with updn high -> upward travel
        cur_req = "R4";
        updn = 1'b1;
        wait_cyc(25);
        sel_n = 1'b0;
        wait_cyc(5);
        check("R3", int'(standby), 0);
        for (int i = 0; i < 3; i++) pulse(1'b0, 20, 20);
        check("R4", int'(wiper_pos), 19);

        // R5: short glitches and the exact-width boundary
        cur_req = "R5";
        pulse(1'b0, 5, 20);
        pulse(1'b0, MINP - 1, 20);
        check("R5", int'(wiper_pos), 19);
        pulse(1'b0, MINP, 20);
        check("R5", int'(wiper_pos), 20);

        // R7: deselect, toggle, reselect keeps the position
        cur_req = "R7";
        sel_n = 1'b1;
        wait_cyc(5);
        check("R7", int'(standby), 1);
        for (int i = 0; i < 3; i++) pulse(1'b0, 20, 20);
        check("R7", int'(wiper_pos), 20);

        // R3/R6: select with updn low -> downward, run past 0
        cur_req = "R6";
        updn = 1'b0;
        wait_cyc(25);
        sel_n = 1'b0;
        wait_cyc(5);
        for (int i = 0; i < 25; i++) pulse(1'b1, 20, 20);
        check("R6", int'(wiper_pos), 0);
        check("R8", int'(tap_en[0]), 1);
        sel_n = 1'b1;
        wait_cyc(5);

        // R6: upward past 31
        updn = 1'b1;
        wait_cyc(25);
        sel_n = 1'b0;
        wait_cyc(5);
        for (int i = 0; i < 35; i++) pulse(1'b0, 20, 20);
        check("R6", int'(wiper_pos), 31);
        check("R8", int'(tap_en[31]), 1);

        // R3: direction held while selected, high then down-style activity
        cur_req = "R3";
        pulse(1'b0, 30, 30);
        check("R3", int'(wiper_pos), 31);
        sel_n = 1'b1;
        wait_cyc(10);
        check("R2", int'(standby), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule